// File: doc/BRIEF.md
# Watchpoint Address Matcher

This block is one hardware breakpoint compare unit for a 32-bit processor. Software programs two 32-bit words through a small register port: a low word with the watched address and per-access-type enables, and a high word with an address mask, an address space identifier, a global flag, read-only chain information and sticky match status. Each cycle the core may present one access (instruction fetch, load or store) with its virtual address and the current address space identifier. When the access qualifies, the block raises a watch request in the same cycle, which the core turns into an exception.

The access input is observe-only. The block samples it whenever `acc_valid` is high and never stalls the core, so there is no ready signal and no back-pressure: every presented access is compared in its own cycle. The register port is plain: a write takes effect at the clock edge, and the read data is combinational from the selected word.

Top module: `wpt_match`

## Requirements
- R1: After reset both words read as zero, except that high-word bit 31 shows the chain parameter. No request is raised for any access until an enable bit has been written.
- R2: The address compare uses bits 31:3 (low-word bits 31:3 against access address bits 31:3). Access address bits 2:0 never affect the result.
- R3: Low-word bit 2 enables fetches, bit 1 enables loads and bit 0 enables stores. `acc_kind` is coded 0 fetch, 1 load, 2 store and 3 none. Kind 3 never matches, and no kind matches when its enable bit is clear.
- R4: High-word bits 11:3 are a mask: a 1 in bit n makes address bit n a don't-care. Address bits 31:12 are always compared exactly.
- R5: When high-word bit 30 (global) is 1, the identifier is ignored. When it is 0, a match also needs `cur_asid` to equal high-word bits 23:16.
- R6: `watch_req` is high in the same cycle as a qualifying access, and only while `acc_valid` is high. It is a single bit however many enables are set.
- R7: High-word status bits 2 (fetch), 1 (load) and 0 (store) are set at the clock edge after a request of that kind and stay set.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. A set in the same cycle as a clear wins.
- R9: High-word bit 31 is read-only and equals the `CHAIN_NEXT` parameter. Bits 29:24 and 15:12 always read zero. Writes to these bits are ignored.
- R10: The low word reads back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Word select: 0 low, 1 high |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected word |
| acc_valid | input | 1 | An access is present this cycle |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 none |
| acc_addr | input | 32 | Access virtual address |
| cur_asid | input | 8 | Current address space identifier |
| watch_req | output | 1 | Watch exception request, same cycle as the access |

## Verification
The hardest case to reach is a status bit being set and cleared in the same cycle. It needs a software write of 1 to that bit to land on exactly the cycle in which a qualifying access of the same kind is presented. The bench builds this case by holding the write strobe and the access valid together across one clock edge, then reading the high word back. The mask boundary at bit 12 and the identifier override are reached through table rows that differ in a single address or identifier bit.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
  localparam int ADDR_W   = 32;
  localparam int ASID_W   = 8;
  localparam int MASK_W   = 9;
  localparam int GRAN_LSB = 3;
  localparam int KINDS    = 3;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  // bit 2 fetch, bit 1 load, bit 0 store
  function automatic logic [KINDS-1:0] kind_onehot(input logic [1:0] k);
    case (k)
      ACC_FETCH: kind_onehot = 3'b100;
      ACC_LOAD:  kind_onehot = 3'b010;
      ACC_STORE: kind_onehot = 3'b001;
      default:   kind_onehot = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/wpt_regs.sv
module wpt_regs
  import wpt_pkg::*;
#(
  parameter bit CHAIN_NEXT = 1'b0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       sel,
  input  logic [ADDR_W-1:0]          wdata,
  input  logic [KINDS-1:0]           set_sts,
  output logic [ADDR_W-1:GRAN_LSB]   watch_addr,
  output logic [KINDS-1:0]           en,
  output logic [MASK_W-1:0]          mask,
  output logic [ASID_W-1:0]          asid,
  output logic                       global_en,
  output logic [KINDS-1:0]           sts,
  output logic [ADDR_W-1:0]          rdata
);
  localparam int MASK_LSB = GRAN_LSB;
  localparam int ASID_LSB = 16;
  localparam int GLB_BIT  = 30;
  localparam int CHN_BIT  = 31;

  logic             wr_lo, wr_hi;
  logic [KINDS-1:0] clr_sts;
  logic [ADDR_W-1:0] lo_word, hi_word;

  assign wr_lo   = wr_en && !sel;
  assign wr_hi   = wr_en && sel;
  assign clr_sts = wr_hi ? wdata[KINDS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      watch_addr <= '0;
      en         <= '0;
      mask       <= '0;
      asid       <= '0;
      global_en  <= 1'b0;
      sts        <= '0;
    end else begin
      if (wr_lo) begin
        watch_addr <= wdata[ADDR_W-1:GRAN_LSB];
        en         <= wdata[KINDS-1:0];
      end
      if (wr_hi) begin
        mask      <= wdata[MASK_LSB +: MASK_W];
        asid      <= wdata[ASID_LSB +: ASID_W];
        global_en <= wdata[GLB_BIT];
      end
      // a new hit outranks a clear in the same cycle
      sts <= (sts & ~clr_sts) | set_sts;
    end
  end

  always_comb begin
    lo_word = {watch_addr, en};
    hi_word = '0;
    hi_word[CHN_BIT]                = CHAIN_NEXT;
    hi_word[GLB_BIT]                = global_en;
    hi_word[ASID_LSB +: ASID_W]     = asid;
    hi_word[MASK_LSB +: MASK_W]     = mask;
    hi_word[KINDS-1:0]              = sts;
    rdata = sel ? hi_word : lo_word;
  end
endmodule

// File: rtl/wpt_cmp.sv
module wpt_cmp
  import wpt_pkg::*;
(
  input  logic                     acc_valid,
  input  logic [1:0]               acc_kind,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [ASID_W-1:0]        cur_asid,
  input  logic [ADDR_W-1:GRAN_LSB] watch_addr,
  input  logic [KINDS-1:0]         en,
  input  logic [MASK_W-1:0]        mask,
  input  logic [ASID_W-1:0]        asid,
  input  logic                     global_en,
  output logic                     req,
  output logic [KINDS-1:0]         hit_kind
);
  logic [ADDR_W-1:GRAN_LSB] care, diff;
  logic [KINDS-1:0]         kind_oh;
  logic                     addr_hit, type_hit, id_hit;

  always_comb begin
    care = '1;
    care[GRAN_LSB +: MASK_W] = ~mask;
    diff     = (acc_addr[ADDR_W-1:GRAN_LSB] ^ watch_addr) & care;
    addr_hit = (diff == '0);
    kind_oh  = kind_onehot(acc_kind);
    type_hit = |(kind_oh & en);
    id_hit   = global_en || (asid == cur_asid);
    req      = acc_valid && type_hit && addr_hit && id_hit;
    hit_kind = req ? kind_oh : '0;
  end
endmodule

// File: rtl/wpt_match.sv
module wpt_match
  import wpt_pkg::*;
#(
  parameter bit CHAIN_NEXT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [31:0]       acc_addr,
  input  logic [7:0]        cur_asid,
  output logic              watch_req
);
  logic [ADDR_W-1:GRAN_LSB] w_addr;
  logic [KINDS-1:0]         w_en, w_sts, w_hit;
  logic [MASK_W-1:0]        w_mask;
  logic [ASID_W-1:0]        w_asid;
  logic                     w_glb;

  wpt_regs #(.CHAIN_NEXT(CHAIN_NEXT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .sel       (reg_sel),
    .wdata     (reg_wdata),
    .set_sts   (w_hit),
    .watch_addr(w_addr),
    .en        (w_en),
    .mask      (w_mask),
    .asid      (w_asid),
    .global_en (w_glb),
    .sts       (w_sts),
    .rdata     (reg_rdata)
  );

  wpt_cmp u_cmp (
    .acc_valid (acc_valid),
    .acc_kind  (acc_kind),
    .acc_addr  (acc_addr),
    .cur_asid  (cur_asid),
    .watch_addr(w_addr),
    .en        (w_en),
    .mask      (w_mask),
    .asid      (w_asid),
    .global_en (w_glb),
    .req       (watch_req),
    .hit_kind  (w_hit)
  );
endmodule

// File: rtl/wpt_match_chk.sv
module wpt_match_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_valid,
  input logic [1:0]  acc_kind,
  input logic        watch_req,
  input logic        reg_wr_en,
  input logic        reg_sel,
  input logic [31:0] reg_rdata,
  input logic [2:0]  sts,
  input logic [2:0]  en
);
  logic [2:0] koh;
  always_comb begin
    case (acc_kind)
      2'd0:    koh = 3'b100;
      2'd1:    koh = 3'b010;
      2'd2:    koh = 3'b001;
      default: koh = 3'b000;
    endcase
  end

  p_req_needs_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    watch_req |-> acc_valid);

  p_req_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    watch_req |-> ((koh & en) != 3'b000));

  p_status_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    watch_req |=> ((sts & $past(koh)) == $past(koh)));

  p_status_no_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !watch_req |=> ((sts & ~$past(sts)) == 3'b000));

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!watch_req && !(reg_wr_en && reg_sel)) |=> $stable(sts));

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel |-> (reg_rdata[29:24] == 6'd0 && reg_rdata[15:12] == 4'd0));
endmodule

bind wpt_match wpt_match_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .acc_valid(acc_valid),
  .acc_kind (acc_kind),
  .watch_req(watch_req),
  .reg_wr_en(reg_wr_en),
  .reg_sel  (reg_sel),
  .reg_rdata(reg_rdata),
  .sts      (w_sts),
  .en       (w_en)
);

// File: tb/wpt_match_bench.sv
module wpt_match_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0, reg_sel = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'd3;
  logic [31:0] acc_addr = '0;
  logic [7:0]  cur_asid = '0;
  logic        watch_req;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wpt_match #(.CHAIN_NEXT(1'b1)) u_wpt_match (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .cur_asid(cur_asid),
    .watch_req(watch_req)
  );

  typedef struct packed {
    logic [31:0] lo;
    logic [31:0] hi;
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [7:0]  asid;
    logic        exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'h1000_0004, 32'h4000_0000, 2'd0, 32'h1000_0000, 8'h00, 1'b1},
    '{32'h1000_0004, 32'h4000_0000, 2'd0, 32'h1000_0007, 8'h00, 1'b1},
    '{32'h1000_0004, 32'h4000_0000, 2'd0, 32'h1000_0008, 8'h00, 1'b0},
    '{32'h1000_0004, 32'h4000_0000, 2'd1, 32'h1000_0000, 8'h00, 1'b0},
    '{32'h1000_0002, 32'h4000_0000, 2'd1, 32'h1000_0000, 8'h00, 1'b1},
    '{32'h1000_0001, 32'h4000_0000, 2'd2, 32'h1000_0000, 8'h00, 1'b1},
    '{32'h1000_0007, 32'h4000_0000, 2'd3, 32'h1000_0000, 8'h00, 1'b0},
    '{32'h2000_0007, 32'h4000_0FF8, 2'd0, 32'h2000_0FF8, 8'h00, 1'b1},
    '{32'h2000_0007, 32'h4000_0FF8, 2'd0, 32'h2000_1000, 8'h00, 1'b0},
    '{32'h2000_0007, 32'h4000_0008, 2'd1, 32'h2000_0008, 8'h00, 1'b1},
    '{32'h2000_0007, 32'h4000_0008, 2'd1, 32'h2000_0010, 8'h00, 1'b0},
    '{32'h3000_0004, 32'h0012_0000, 2'd0, 32'h3000_0000, 8'h12, 1'b1},
    '{32'h3000_0004, 32'h0012_0000, 2'd0, 32'h3000_0000, 8'h13, 1'b0},
    '{32'h3000_0004, 32'h4012_0000, 2'd0, 32'h3000_0000, 8'h13, 1'b1},
    '{32'h3000_0004, 32'h0012_0000, 2'd2, 32'h3000_0000, 8'h12, 1'b0},
    '{32'h8000_0001, 32'h4000_0000, 2'd2, 32'h8000_0000, 8'h00, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] d);
    @(negedge clk);
    reg_sel = sel;
    #1 d = reg_rdata;
  endtask

  // presents one access across one edge; returns request seen mid-cycle
  task automatic acc(input logic [1:0] k, input logic [31:0] a, input logic [7:0] id,
                     input logic v, output logic r);
    @(negedge clk);
    acc_valid = v; acc_kind = k; acc_addr = a; cur_asid = id;
    #1 r = watch_req;
    @(negedge clk);
    acc_valid = 1'b0; acc_kind = 2'd3;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(1'b0, d); chk("R1 low word reset", d, 32'h0);
    rd(1'b1, d); chk("R1 high word reset", d, 32'h8000_0000);
    acc(2'd0, 32'h0, 8'h00, 1'b1, r); chk("R1 no request before enable", {31'd0, r}, 32'd0);

    // table: R2/R3/R4/R5 compare cases
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, VEC[i].lo);
      wr(1'b1, VEC[i].hi);
      acc(VEC[i].kind, VEC[i].addr, VEC[i].asid, 1'b1, r);
      chk($sformatf("R2/R3/R4/R5 table row %0d", i), {31'd0, r}, {31'd0, VEC[i].exp});
    end

    // R10 low word readback
    wr(1'b0, 32'hDEAD_BEEF);
    rd(1'b0, d); chk("R10 low word readback", d, 32'hDEAD_BEEF);

    // R9 read-only and reserved bits; ones in status bits also clear them (R8)
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, d); chk("R9 high word all-ones write", d, 32'hC0FF_0FF8);
    wr(1'b1, 32'h0000_0000);
    rd(1'b1, d); chk("R9 chain bit survives zero write", d, 32'h8000_0000);

    // R6 no request without valid
    wr(1'b0, 32'h4000_0007);
    wr(1'b1, 32'h4000_0000);
    acc(2'd1, 32'h4000_0000, 8'h00, 1'b0, r); chk("R6 no request without valid", {31'd0, r}, 32'd0);
    rd(1'b1, d); chk("R6 status untouched without valid", d, 32'hC000_0000);

    // R7 sticky status
    acc(2'd1, 32'h4000_0000, 8'h00, 1'b1, r); chk("R6 same-cycle request", {31'd0, r}, 32'd1);
    rd(1'b1, d); chk("R7 load status set", d, 32'hC000_0002);
    acc(2'd0, 32'h4000_0004, 8'h00, 1'b1, r);
    repeat (4) @(negedge clk);
    rd(1'b1, d); chk("R7 fetch status set and sticky", d, 32'hC000_0006);

    // R8 write-one-to-clear
    wr(1'b1, 32'h4000_0000);
    rd(1'b1, d); chk("R8 zero write leaves status", d, 32'hC000_0006);
    wr(1'b1, 32'h4000_0004);
    rd(1'b1, d); chk("R8 one clears fetch status", d, 32'hC000_0002);

    // R8 set wins over clear in the same cycle
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h4000_0002;
    acc_valid = 1'b1; acc_kind = 2'd1; acc_addr = 32'h4000_0000; cur_asid = 8'h00;
    @(negedge clk);
    reg_wr_en = 1'b0; acc_valid = 1'b0; acc_kind = 2'd3;
    rd(1'b1, d); chk("R8 set beats clear", d, 32'hC000_0002);
    wr(1'b1, 32'h4000_0002);
    rd(1'b1, d); chk("R8 clear without hit", d, 32'hC000_0000);

    finish_run();
  end
endmodule